// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

The controller collects fifteen edge-triggered interrupt request lines and presents one interrupt output to a processor. It is built from two identical eight-input priority stages. The secondary stage's interrupt output is wired into input 2 of the primary stage, and the primary stage drives the processor. Each stage records rising edges into pending bits and ignores the lines its mask register blocks. When the stage is idle it picks the lowest-numbered pending, unmasked input and latches an 8-bit vector. That vector is a programmable 5-bit base followed by the 3-bit input index.

The processor uses a two-address register port with a stage select. Address 0 is the command and vector port: a read returns the current vector, a write with bit 5 set retires the interrupt in service, and a write with bit 4 set and bit 5 clear starts a base-load sequence. Address 1 holds the mask. When the primary stage is serving its cascade input, a read of the primary vector returns the secondary stage's vector. In that case a single acknowledge write retires both stages. The interrupt output stays high from the moment a vector is latched until that acknowledge arrives.

Top module: `cascade_intc`

## Requirements
- R1: After reset the interrupt output is low and both mask registers read 0xFF, so every input is masked.
- R2: Requests are edge-triggered: a 0-to-1 transition on an input sets its pending bit, and a line held high after its interrupt is retired raises no second interrupt.
- R3: Within a stage, the lowest-numbered input that is both pending and unmasked wins. At the primary stage the cascade input (2) therefore outranks primary inputs 3 to 7 and yields to inputs 0 and 1.
- R4: The vector is the stage base in bits 7:3 and the winning input index in bits 2:0. A read of address 0 returns it.
- R5: Once a vector is latched the interrupt output goes high, and it stays high with the vector unchanged until a primary-stage address-0 write with bit 5 set. After that write the output is low in the following cycle.
- R6: Setting mask bit i blocks input i, and a masked input never raises the interrupt output. A request captured while masked stays pending and is served once the bit is cleared.
- R7: External line mapping: lines 0 and 1 feed primary inputs 0 and 1, lines 2 to 6 feed primary inputs 3 to 7, and lines 7 to 14 feed secondary inputs 0 to 7. While the primary stage is serving input 2, a primary address-0 read returns the secondary vector.
- R8: One acknowledge write to the primary stage, made while it serves input 2, retires both the primary and the secondary interrupt.
- R9: An address-0 write with bit 5 clear and bit 4 set arms a base load. The next address-1 write to that stage loads the base from data bits 7:3 and leaves the mask unchanged. Later address-1 writes load the mask.
- R10: An acknowledge written while no interrupt is in service has no effect, and pending requests are kept.
- R11: A read of address 1 returns the selected stage's mask.
- R12: Stage select 0 addresses the primary stage and 1 the secondary stage. A write changes only the selected stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 15 | External interrupt request lines |
| stage_sel | input | 1 | 0 selects the primary stage, 1 the secondary stage |
| addr | input | 1 | Register address: 0 command/vector, 1 mask/base |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected stage and address |
| intr | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending bit or a bad priority choice shows up at the vector read as soon as the interrupt rises, two cycles after the request edge for a primary input and four for a secondary input. A busy flag that fails to clear in either stage keeps the interrupt output high. A stuck secondary stage means the next queued secondary vector never arrives within the bench's bounded wait. A mask or base written to the wrong place shows up on the next register read-back, or as an interrupt that appears where none was allowed.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int STAGE_N  = 8;
  localparam int BASE_W   = 5;
  localparam int DATA_W   = 8;
  localparam int ACK_BIT  = 5;
  localparam int INIT_BIT = 4;
  localparam int CASC_IN  = 2;

  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    // scan downward so the lowest set index is the one kept
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_stage.sv
module intc_stage
  import intc_pkg::*;
#(
  parameter int N  = STAGE_N,
  parameter int IW = $clog2(N),
  parameter int BW = BASE_W,
  parameter int DW = DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           wr_en,
  input  logic           addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           ack_ext,
  output logic           intr,
  output logic [IW-1:0]  idx,
  output logic [BW+IW-1:0] vec,
  output logic [N-1:0]   mask
);
  logic [N-1:0]  req_q, pend_q, mask_q;
  logic [N-1:0]  pend_d, rise, clr, cand;
  logic [BW-1:0] base_q;
  logic [IW-1:0] idx_q, win;
  logic          busy_q, arm_q, hit;
  logic          cmd_wr, reg_wr, ack, retire, take;
  logic          busy_en, busy_d, arm_en, arm_d, mask_en, base_en;

  intc_prio_enc #(.N(N), .IW(IW)) u_enc (
    .req (cand),
    .hit (hit),
    .idx (win)
  );

  always_comb begin
    cmd_wr  = wr_en && !addr;
    reg_wr  = wr_en && addr;
    ack     = (cmd_wr && wr_data[ACK_BIT]) || ack_ext;
    retire  = ack && busy_q;
    rise    = req & ~req_q;
    clr     = '0;
    if (retire) clr[idx_q] = 1'b1;
    pend_d  = (pend_q & ~clr) | rise;
    cand    = pend_q & ~mask_q;
    take    = !busy_q && hit;
    busy_en = retire || take;
    busy_d  = take;
    arm_en  = (cmd_wr && !wr_data[ACK_BIT] && wr_data[INIT_BIT]) || reg_wr;
    arm_d   = cmd_wr;
    mask_en = reg_wr && !arm_q;
    base_en = reg_wr && arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
      base_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
      if (mask_en) mask_q <= wr_data[N-1:0];
      if (base_en) base_q <= wr_data[DW-1 -: BW];
      if (take)    idx_q  <= win;
      if (busy_en) busy_q <= busy_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  assign intr = busy_q;
  assign idx  = idx_q;
  assign vec  = {base_q, idx_q};
  assign mask = mask_q;
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter int N    = STAGE_N,
  parameter int CASC = CASC_IN,
  parameter int BW   = BASE_W,
  parameter int DW   = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N-2:0]    irq_lines,
  input  logic              stage_sel,
  input  logic              addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              intr
);
  localparam int IW     = $clog2(N);
  localparam int NLINES = 2 * N - 1;
  localparam int VW     = BW + IW;

  logic          rst_meta, rst_n_s;
  logic [N-1:0]  pri_req, sec_req, pri_mask, sec_mask;
  logic [IW-1:0] pri_idx, sec_idx;
  logic [VW-1:0] pri_vec, sec_vec;
  logic          pri_intr, sec_intr;
  logic          wr_pri, wr_sec, pri_ack_cmd, casc_ack, pri_on_casc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_pri_map
    if (j == CASC) begin : g_casc
      assign pri_req[j] = sec_intr;
    end else if (j < CASC) begin : g_low
      assign pri_req[j] = irq_lines[j];
    end else begin : g_high
      assign pri_req[j] = irq_lines[j-1];
    end
  end
  assign sec_req = irq_lines[NLINES-1 -: N];

  always_comb begin
    wr_pri      = wr_en && !stage_sel;
    wr_sec      = wr_en && stage_sel;
    pri_on_casc = (pri_idx == IW'(CASC));
    pri_ack_cmd = wr_pri && !addr && wr_data[ACK_BIT];
    casc_ack    = pri_ack_cmd && pri_intr && pri_on_casc;
  end

  intc_stage #(.N(N), .IW(IW), .BW(BW), .DW(DW)) u_pri (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req     (pri_req),
    .wr_en   (wr_pri),
    .addr    (addr),
    .wr_data (wr_data),
    .ack_ext (1'b0),
    .intr    (pri_intr),
    .idx     (pri_idx),
    .vec     (pri_vec),
    .mask    (pri_mask)
  );

  intc_stage #(.N(N), .IW(IW), .BW(BW), .DW(DW)) u_sec (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req     (sec_req),
    .wr_en   (wr_sec),
    .addr    (addr),
    .wr_data (wr_data),
    .ack_ext (casc_ack),
    .intr    (sec_intr),
    .idx     (sec_idx),
    .vec     (sec_vec),
    .mask    (sec_mask)
  );

  always_comb begin
    if (stage_sel)
      rd_data = addr ? DW'(sec_mask) : DW'(sec_vec);
    else if (addr)
      rd_data = DW'(pri_mask);
    else
      rd_data = pri_on_casc ? DW'(sec_vec) : DW'(pri_vec);
  end

  assign intr = pri_intr;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N    = 8,
  parameter int IW   = 3,
  parameter int CASC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          intr,
  input logic          sec_intr,
  input logic          pri_ack_cmd,
  input logic [IW-1:0] pri_idx,
  input logic [IW-1:0] sec_idx,
  input logic [N-1:0]  pri_mask,
  input logic [N-1:0]  sec_mask
);
  logic [N-1:0] pmask_d, smask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_d <= '1;
      smask_d <= '1;
    end else begin
      pmask_d <= pri_mask;
      smask_d <= sec_mask;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !intr);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !pri_ack_cmd |=> intr);

  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    intr && pri_ack_cmd |=> !intr);

  a_r4_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !pri_ack_cmd |=> $stable(pri_idx));

  a_r6_pri_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> !pmask_d[pri_idx]);

  a_r6_sec_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_intr) |-> !smask_d[sec_idx]);

  a_r8_joint_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr) && ($past(pri_idx) == IW'(CASC)) && $past(sec_intr) |-> !sec_intr);
endmodule

bind cascade_intc intc_checker #(.N(N), .IW(IW), .CASC(CASC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .intr        (pri_intr),
  .sec_intr    (sec_intr),
  .pri_ack_cmd (pri_ack_cmd),
  .pri_idx     (pri_idx),
  .sec_idx     (sec_idx),
  .pri_mask    (pri_mask),
  .sec_mask    (sec_mask)
);

// File: tb/sim_cascade_intc.sv
module sim_cascade_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_lines = '0;
  logic        stage_sel = 1'b0;
  logic        addr = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        intr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expq[$];
  logic       seen = 1'b0;

  always #5 clk = ~clk;

  cascade_intc u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .stage_sel (stage_sel),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .intr      (intr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: every new interrupt must carry the next expected vector
  always @(negedge clk) begin
    if (rst_n) begin
      if (intr && !seen) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4 unexpected interrupt", rd_data, 0);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(rd_data == e, "R4 vector", rd_data, e);
        end
      end
      seen = intr;
    end
  end

  task automatic wr(input logic sel, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    stage_sel = sel; addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; stage_sel = 1'b0; addr = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic sel, input logic a, output logic [7:0] d);
    @(posedge clk); #1;
    stage_sel = sel; addr = a;
    @(negedge clk);
    d = rd_data;
    stage_sel = 1'b0; addr = 1'b0;
  endtask

  task automatic ack();
    wr(1'b0, 1'b0, 8'h20);
    @(negedge clk);
    check(intr == 1'b0, "R5 low after acknowledge", intr, 0);
  endtask

  task automatic wait_intr(input string req);
    bit got = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (intr) begin
        got = 1'b1;
        break;
      end
    end
    check(got, req, got, 1);
  endtask

  task automatic serve(input string req);
    wait_intr(req);
    ack();
  endtask

  task automatic pulse2(input int k1, input int k2);
    @(posedge clk); #1;
    irq_lines[k1] = 1'b1; irq_lines[k2] = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    irq_lines[k1] = 1'b0; irq_lines[k2] = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check(intr == 1'b0, "R1 intr after reset", intr, 0);
    rd(1'b0, 1'b1, d); check(d == 8'hFF, "R1 primary mask", d, 8'hFF);
    rd(1'b1, 1'b1, d); check(d == 8'hFF, "R1 secondary mask", d, 8'hFF);

    // R9 base load sequence
    wr(1'b0, 1'b0, 8'h10); wr(1'b0, 1'b1, 8'h20);
    wr(1'b1, 1'b0, 8'h10); wr(1'b1, 1'b1, 8'h70);
    rd(1'b0, 1'b0, d); check(d == 8'h20, "R9 primary base", d, 8'h20);
    rd(1'b1, 1'b0, d); check(d == 8'h70, "R9 secondary base", d, 8'h70);
    rd(1'b0, 1'b1, d); check(d == 8'hFF, "R9 mask untouched by base load", d, 8'hFF);

    // R11 / R12 mask read-back and stage isolation
    wr(1'b0, 1'b1, 8'h5A);
    rd(1'b0, 1'b1, d); check(d == 8'h5A, "R11 mask read", d, 8'h5A);
    rd(1'b1, 1'b1, d); check(d == 8'hFF, "R12 other stage unchanged", d, 8'hFF);
    wr(1'b0, 1'b1, 8'h00); wr(1'b1, 1'b1, 8'h00);

    // R3 lowest primary input wins; R5 output held until acknowledge
    expq.push_back(8'h21); expq.push_back(8'h25);
    pulse2(4, 1);
    wait_intr("R3 first interrupt");
    repeat (5) @(negedge clk);
    check(intr == 1'b1, "R5 held without acknowledge", intr, 1);
    ack();
    serve("R3 second interrupt");

    // R2 a held level gives one interrupt only
    expq.push_back(8'h20);
    @(posedge clk); #1 irq_lines[0] = 1'b1;
    serve("R2 edge interrupt");
    repeat (10) @(negedge clk);
    check(intr == 1'b0, "R2 no retrigger on held level", intr, 0);
    @(posedge clk); #1 irq_lines[0] = 1'b0;

    // R6 masked input waits, then is served after unmask
    wr(1'b0, 1'b1, 8'h01);
    pulse2(0, 0);
    repeat (10) @(negedge clk);
    check(intr == 1'b0, "R6 masked input silent", intr, 0);
    expq.push_back(8'h20);
    wr(1'b0, 1'b1, 8'h00);
    serve("R6 served after unmask");

    // R7 secondary vector through primary; R8 one ack retires both
    expq.push_back(8'h72); expq.push_back(8'h75);
    pulse2(9, 12);
    serve("R7 cascade interrupt");
    serve("R8 next secondary after joint ack");
    repeat (10) @(negedge clk);
    check(intr == 1'b0, "R8 nothing left outstanding", intr, 0);

    // R3 primary input 0 beats the cascade input
    expq.push_back(8'h20); expq.push_back(8'h70);
    pulse2(0, 7);
    serve("R3 input 0 before cascade");
    serve("R3 cascade after input 0");

    // R3 cascade input beats primary input 3 when both wait
    expq.push_back(8'h27);
    @(posedge clk); #1 irq_lines[6] = 1'b1;
    wait_intr("R3 input 7 taken");
    @(posedge clk); #1 irq_lines[6] = 1'b0;
    pulse2(2, 8);
    repeat (6) @(negedge clk);
    expq.push_back(8'h71); expq.push_back(8'h23);
    ack();
    serve("R3 cascade before input 3");
    serve("R3 input 3 last");

    // R10 acknowledge with nothing in service keeps pending
    wr(1'b0, 1'b1, 8'h02);
    pulse2(1, 1);
    ack();
    expq.push_back(8'h21);
    wr(1'b0, 1'b1, 8'h00);
    serve("R10 pending survives stray acknowledge");

    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R4 all expected vectors seen", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule